// File: doc/BRIEF.md
# Block Sequence Number Source

This block frames a sampled data stream into fixed-length blocks. On the data side it drives a one-sample-per-clock output whose strobes mark the first and last sample of every block. Each block carries a 48-bit sequence number, and every block that opens a sync interval also carries a sync flag. The block produces no payload. It only generates the timing and numbering that a payload path attaches to its samples.

Software controls the block through a small register port with four 32-bit words:

- **Word 0** holds the enable bit and a write-one bit that arms a restart.
- **Word 1** reports the fixed interval length in blocks.
- **Words 2 and 3** hold the starting sequence number.

Setting the enable bit on an idle block starts framing at once from the programmed start number. An armed restart waits for the next external once-per-second timing pulse (PPS). On that pulse the sequence number reloads and the sync interval realigns, with no need to drop the enable. The enable and the armed flag reach the data path through a register synchroniser.

Top module: `blkseq_source`

## Requirements
- R1: After reset the output is idle (`out_valid` low) and word 0 reads as zero.
- R2: A write to word 0 sets the enable from bit 0, and a 1 in bit 1 arms a restart. A read of word 0 returns the enable in bit 0 and the armed flag in bit 1.
- R3: Word 2 holds bits 31:0 of the start number and word 3 holds bits 47:32 in its low 16 bits; both read back. Word 1 reads as `BLOCKS_PER_SYNC`.
- R4: When enable is set while idle and no restart is armed, blocks begin with the start number as their sequence number, and the first block is flagged sync.
- R5: Within a block, `out_valid` stays high on every cycle. `out_sop` marks sample 0, `out_eop` marks sample `SAMPLES_PER_BLOCK-1`, and `out_bsn` stays constant.
- R6: Each following block's sequence number is one greater than the last, with carry across bit 32.
- R7: `out_sync` is high only together with `out_sop`. It is high on every block whose index within the interval is zero, counting from the last start or restart, so once every `BLOCKS_PER_SYNC` blocks.
- R8: After enable is cleared, the current block runs to its last sample and no further block starts.
- R9: With a restart armed and enable set, a PPS pulse makes the next cycle a sync-flagged first sample carrying the start number. Any block in progress is cut short.
- R10: A restart armed while disabled produces no output until enable and PPS are both present. The armed flag clears once the restart is taken, and a PPS pulse that lasts several cycles restarts only once.
- R11: A PPS pulse with no restart armed has no effect on the stream, whether the block is running or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register port and data path |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| reg_rdvalid | output | 1 | Read data valid |
| pps | input | 1 | External timing pulse |
| out_valid | output | 1 | Sample slot valid |
| out_sop | output | 1 | First sample of a block |
| out_eop | output | 1 | Last sample of a block |
| out_sync | output | 1 | Block opens a sync interval |
| out_bsn | output | BSN_W | Block sequence number |

## Verification
The bench starts from a start number just below a 32-bit boundary, so a block that drops the carry into the upper word shows a wrong sequence number within two blocks. It disables the block in the middle of a block and watches for a truncated block or an extra block afterwards. It arms a restart while the block is disabled and expects complete silence until the PPS pulse; a design that starts early on the enable alone emits unexpected blocks. It also restarts mid-block with a two-cycle PPS pulse, which a design lacking the consume guard would act on twice. Finally, it sends PPS pulses with nothing armed, which a design that reloads on every pulse would turn into a spurious renumbering.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;
   localparam int REG_DW = 32;
   localparam int REG_AW = 2;
   // Register word select values
   localparam logic [REG_AW-1:0] ADR_CTRL    = 2'd0;
   localparam logic [REG_AW-1:0] ADR_PERIOD  = 2'd1;
   localparam logic [REG_AW-1:0] ADR_START_L = 2'd2;
   localparam logic [REG_AW-1:0] ADR_START_H = 2'd3;
   // Control word bit positions
   localparam int CTRL_EN  = 0;
   localparam int CTRL_ARM = 1;
endpackage

// File: rtl/blkseq_regs.sv
module blkseq_regs
   import blkseq_pkg::*;
#(
   parameter int BSN_W           = 48,
   parameter int BLOCKS_PER_SYNC = 48
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic              rd,
   input  logic [REG_AW-1:0] addr,
   input  logic [REG_DW-1:0] wdata,
   output logic [REG_DW-1:0] rdata,
   output logic              rdvalid,
   input  logic              consume,
   output logic              en,
   output logic              armed,
   output logic [BSN_W-1:0]  start_bsn
);
   localparam int HI_W = BSN_W - REG_DW;

   logic [REG_DW-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      case (addr)
         ADR_CTRL: begin
            rd_mux[CTRL_EN]  = en;
            rd_mux[CTRL_ARM] = armed;
         end
         ADR_PERIOD:  rd_mux = REG_DW'(BLOCKS_PER_SYNC);
         ADR_START_L: rd_mux = start_bsn[REG_DW-1:0];
         ADR_START_H: rd_mux[HI_W-1:0] = start_bsn[BSN_W-1:REG_DW];
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         en        <= 1'b0;
         armed     <= 1'b0;
         start_bsn <= '0;
         rdata     <= '0;
         rdvalid   <= 1'b0;
      end else begin
         rdvalid <= rd;
         if (rd) rdata <= rd_mux;
         if (consume) armed <= 1'b0;
         if (wr) begin
            case (addr)
               ADR_CTRL: begin
                  en <= wdata[CTRL_EN];
                  if (wdata[CTRL_ARM]) armed <= 1'b1;
               end
               ADR_START_L: start_bsn[REG_DW-1:0]     <= wdata;
               ADR_START_H: start_bsn[BSN_W-1:REG_DW] <= wdata[HI_W-1:0];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/blkseq_sync.sv
module blkseq_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe;
         always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/blkseq_framer.sv
module blkseq_framer #(
   parameter int BSN_W             = 48,
   parameter int SAMPLES_PER_BLOCK = 1024,
   parameter int BLOCKS_PER_SYNC   = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_s,
   input  logic             armed_s,
   input  logic             pps,
   input  logic [BSN_W-1:0] start_bsn,
   output logic             consume,
   output logic             valid,
   output logic             sop,
   output logic             eop,
   output logic             sync,
   output logic [BSN_W-1:0] bsn
);
   localparam int SW = $clog2(SAMPLES_PER_BLOCK);
   localparam int BW = (BLOCKS_PER_SYNC > 1) ? $clog2(BLOCKS_PER_SYNC) : 1;
   localparam logic [SW-1:0] SMP_LAST = SW'(SAMPLES_PER_BLOCK - 1);
   localparam logic [BW-1:0] BLK_LAST = BW'(BLOCKS_PER_SYNC - 1);

   logic          run;
   logic [SW-1:0] smp;
   logic [BW-1:0] blk;
   logic          ack_wait;

   // Restart is taken once per armed request; ack_wait masks the
   // synchroniser lag of the cleared armed flag.
   assign consume = armed_s & en_s & pps & ~ack_wait;

   always_ff @(posedge clk) begin
      if (rst) begin
         run      <= 1'b0;
         smp      <= '0;
         blk      <= '0;
         bsn      <= '0;
         ack_wait <= 1'b0;
      end else begin
         if (consume)       ack_wait <= 1'b1;
         else if (!armed_s) ack_wait <= 1'b0;

         if (consume) begin
            run <= 1'b1;
            smp <= '0;
            blk <= '0;
            bsn <= start_bsn;
         end else if (run) begin
            if (smp == SMP_LAST) begin
               smp <= '0;
               if (en_s) begin
                  blk <= (blk == BLK_LAST) ? '0 : blk + 1'b1;
                  bsn <= bsn + 1'b1;
               end else begin
                  run <= 1'b0;
               end
            end else begin
               smp <= smp + 1'b1;
            end
         end else if (en_s && !armed_s) begin
            run <= 1'b1;
            smp <= '0;
            blk <= '0;
            bsn <= start_bsn;
         end
      end
   end

   assign valid = run;
   assign sop   = run && (smp == '0);
   assign eop   = run && (smp == SMP_LAST);
   assign sync  = sop && (blk == '0);
endmodule

// File: rtl/blkseq_source.sv
module blkseq_source
   import blkseq_pkg::*;
#(
   parameter int BSN_W             = 48,
   parameter int SAMPLES_PER_BLOCK = 1024,
   parameter int BLOCKS_PER_SYNC   = 48,
   parameter int SYNC_STAGES       = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             reg_rdvalid,
   input  logic             pps,
   output logic             out_valid,
   output logic             out_sop,
   output logic             out_eop,
   output logic             out_sync,
   output logic [BSN_W-1:0] out_bsn
);
   generate
      if (BSN_W <= REG_DW || BSN_W > 2*REG_DW) begin : g_bad_bsn
         $error("BSN_W must lie in 33..64");
      end
      if (SAMPLES_PER_BLOCK < 2) begin : g_bad_spb
         $error("SAMPLES_PER_BLOCK must be at least 2");
      end
      if (BLOCKS_PER_SYNC < 1) begin : g_bad_bps
         $error("BLOCKS_PER_SYNC must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             en_r, armed_r, en_s, armed_s, consume;
   logic [BSN_W-1:0] start_bsn;

   blkseq_regs #(.BSN_W(BSN_W), .BLOCKS_PER_SYNC(BLOCKS_PER_SYNC)) u_regs (
      .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .rdvalid(reg_rdvalid),
      .consume(consume), .en(en_r), .armed(armed_r), .start_bsn(start_bsn)
   );

   // Enable and armed cross together so they can never disagree in the data path.
   blkseq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d({armed_r, en_r}), .q({armed_s, en_s})
   );

   blkseq_framer #(
      .BSN_W(BSN_W), .SAMPLES_PER_BLOCK(SAMPLES_PER_BLOCK),
      .BLOCKS_PER_SYNC(BLOCKS_PER_SYNC)
   ) u_framer (
      .clk(clk), .rst(rst), .en_s(en_s), .armed_s(armed_s), .pps(pps),
      .start_bsn(start_bsn), .consume(consume), .valid(out_valid),
      .sop(out_sop), .eop(out_eop), .sync(out_sync), .bsn(out_bsn)
   );
endmodule

// File: rtl/blkseq_source_chk.sv
module blkseq_source_chk #(
   parameter int BSN_W = 48
) (
   input logic             clk,
   input logic             rst,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic             armed_r,
   input logic             en_s,
   input logic             consume,
   input logic [BSN_W-1:0] start_bsn,
   input logic             out_valid,
   input logic             out_sop,
   input logic             out_eop,
   input logic             out_sync,
   input logic [BSN_W-1:0] out_bsn
);
   // R7
   sync_on_sop_chk: assert property (@(posedge clk) disable iff (rst)
      out_sync |-> out_sop);

   // R5
   eop_in_valid_chk: assert property (@(posedge clk) disable iff (rst)
      out_eop |-> out_valid);

   // R5
   bsn_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_sop) |-> $stable(out_bsn));

   // R6
   bsn_step_chk: assert property (@(posedge clk) disable iff (rst)
      (out_sop && $past(out_eop) && !$past(consume)) |-> out_bsn == $past(out_bsn) + BSN_W'(1));

   // R8
   no_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_eop) |=> out_valid);

   // R4
   start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(en_s));

   // R9
   restart_frame_chk: assert property (@(posedge clk) disable iff (rst)
      consume |=> (out_sop && out_sync && out_bsn == $past(start_bsn)));

   // R10
   arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (consume && !(reg_wr && reg_addr == 2'd0 && reg_wdata[1])) |=> !armed_r);
endmodule

bind blkseq_source blkseq_source_chk #(.BSN_W(BSN_W)) u_chk (
   .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .armed_r(armed_r), .en_s(en_s), .consume(consume),
   .start_bsn(start_bsn), .out_valid(out_valid), .out_sop(out_sop),
   .out_eop(out_eop), .out_sync(out_sync), .out_bsn(out_bsn)
);

// File: tb/tb_blkseq_source.sv
`timescale 1ns/1ps
module tb_blkseq_source;
   localparam int SPB = 8;
   localparam int BPS = 4;

   typedef struct {
      logic [47:0] bsn;
      logic        sync;
   } blk_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, pps = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_rdvalid;
   logic        out_valid, out_sop, out_eop, out_sync;
   logic [47:0] out_bsn;

   int   checks = 0;
   int   failures = 0;
   blk_t exp_q[$];

   always #5 clk = ~clk;

   blkseq_source #(.BSN_W(48), .SAMPLES_PER_BLOCK(SPB), .BLOCKS_PER_SYNC(BPS),
                   .SYNC_STAGES(2)) dut (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rdvalid(reg_rdvalid),
      .pps(pps), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
      .out_sync(out_sync), .out_bsn(out_bsn)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); reg_rd = 1'b0;
      d = reg_rdata;
      chk(reg_rdvalid == 1'b1, "R2", "read valid strobe", 64'(reg_rdvalid), 64'd1);
   endtask

   task automatic push_blk(input logic [47:0] b, input logic s);
      blk_t e;
      e.bsn = b; e.sync = s;
      exp_q.push_back(e);
   endtask

   task automatic pulse_pps(input int n);
      @(negedge clk); pps = 1'b1;
      repeat (n) @(negedge clk);
      pps = 1'b0;
   endtask

   task automatic wait_left(input int n);
      while (exp_q.size() > n) @(negedge clk);
   endtask

   task automatic idle_check(input int settle, input int span, input string req);
      int seen = 0;
      repeat (settle) @(negedge clk);
      for (int i = 0; i < span; i++) begin
         @(negedge clk);
         if (out_valid) seen++;
      end
      chk(seen == 0, req, "valid cycles while idle", 64'(seen), 64'd0);
   endtask

   // Monitor: pops one expected block per first-sample strobe
   logic in_blk = 1'b0;
   int   cnt = 0;
   always @(negedge clk) begin
      if (!rst) begin
         if (out_valid) begin
            if (out_sop) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R8", "unexpected block bsn", 64'(out_bsn), 64'd0);
               end else begin
                  blk_t e;
                  e = exp_q.pop_front();
                  chk(out_bsn == e.bsn, "R6", "block bsn", 64'(out_bsn), 64'(e.bsn));
                  chk(out_sync == e.sync, "R7", "sync flag", 64'(out_sync), 64'(e.sync));
               end
               in_blk = 1'b1;
               cnt = 0;
            end else begin
               if (!in_blk) chk(1'b0, "R5", "valid outside block", 64'd1, 64'd0);
               cnt++;
               if (out_sync) chk(1'b0, "R7", "sync without sop", 64'd1, 64'd0);
            end
            if (out_eop) begin
               chk(cnt == SPB - 1, "R5", "eop sample index", 64'(cnt), 64'(SPB - 1));
               in_blk = 1'b0;
            end
         end else if (in_blk) begin
            chk(1'b0, "R5", "gap inside block", 64'(cnt), 64'(SPB - 1));
            in_blk = 1'b0;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [47:0] base;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(out_valid == 1'b0, "R1", "valid after reset", 64'(out_valid), 64'd0);
      reg_read(2'd0, d);
      chk(d == 32'd0, "R1", "control word after reset", 64'(d), 64'd0);
      // R3 period word and start number
      reg_read(2'd1, d);
      chk(d == BPS, "R3", "blocks per sync", 64'(d), 64'(BPS));
      reg_write(2'd2, 32'hFFFF_FFFE);
      reg_write(2'd3, 32'h0000_0001);
      reg_read(2'd2, d);
      chk(d == 32'hFFFF_FFFE, "R3", "start low word", 64'(d), 64'hFFFF_FFFE);
      reg_read(2'd3, d);
      chk(d == 32'h1, "R3", "start high word", 64'(d), 64'h1);

      // R4 R6 R7 free-running start with carry across bit 32
      base = 48'h0001_FFFF_FFFE;
      for (int k = 0; k < 6; k++) push_blk(base + 48'(k), (k % BPS) == 0);
      reg_write(2'd0, 32'h1);
      wait_left(0);
      // R8 disable mid-block: block finishes, nothing follows
      reg_write(2'd0, 32'h0);
      idle_check(12, 30, "R8");

      // R10 restart armed while disabled waits for PPS
      reg_write(2'd2, 32'd16);
      reg_write(2'd3, 32'd0);
      reg_write(2'd0, 32'h3);
      idle_check(0, 30, "R10");
      reg_read(2'd0, d);
      chk(d == 32'h3, "R2", "enable and armed read back", 64'(d), 64'h3);
      for (int k = 0; k < 6; k++) push_blk(48'd16 + 48'(k), (k % BPS) == 0);
      pulse_pps(1);
      wait_left(0);
      reg_read(2'd0, d);
      chk(d == 32'h1, "R10", "armed flag cleared", 64'(d), 64'h1);

      // R9 restart while running, two-cycle PPS mid-block
      push_blk(48'd22, 1'b0);
      push_blk(48'd23, 1'b0);
      push_blk(48'd100, 1'b1);
      reg_write(2'd2, 32'd100);
      reg_write(2'd0, 32'h3);
      wait_left(1);
      repeat (3) @(negedge clk);
      pulse_pps(2);
      wait_left(0);

      // R11 PPS with nothing armed while running
      push_blk(48'd101, 1'b0);
      push_blk(48'd102, 1'b0);
      push_blk(48'd103, 1'b0);
      push_blk(48'd104, 1'b1);
      wait_left(2);
      pulse_pps(1);
      wait_left(0);
      reg_write(2'd0, 32'h0);
      idle_check(12, 10, "R8");
      // R11 PPS while idle and not armed
      pulse_pps(1);
      idle_check(0, 30, "R11");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule